// File: doc/BRIEF.md
# Serial Byte Link with Hardware Handshake

This block is a full-duplex asynchronous serial port carrying 8 data bits, no parity and one stop bit. Bytes to transmit enter through a valid/ready pair and leave on `txd_o`. Bytes arriving on `rxd_i` are collected in a 16-entry buffer and handed out through a second valid/ready pair.

Pacing in both directions is handled in logic alone, with no register writes from software. The peer's request-to-send line arrives on `cts_i`, and a new frame may begin only while it reads 1. `rts_o` rises when the receive buffer is full, which tells the peer to hold off. Both incoming lines pass through two-flop synchronizers. The bit time is set by the `CLKS_PER_BIT` parameter. The receiver oversamples each bit 16 times, checks that a start bit is real, and samples at the middle of every bit.

Top module: `uart_fc`

## Requirements
- R1: After reset, `txd_o` is 1 and `rts_o`, `overrun_o`, `rx_valid_o` and `tx_ready_o` are 0.
- R2: A byte taken on `tx_valid_i && tx_ready_o` is sent as one 0 start bit, then the 8 data bits least significant first, then one 1 stop bit. Each bit lasts `CLKS_PER_BIT` clocks.
- R3: `tx_ready_o` is 1 only while the transmitter is idle and the synchronized `cts_i` (two flops) is 1. While `cts_i` is 0, no frame starts and `txd_o` stays 1.
- R4: A frame that has already started always finishes intact, even if `cts_i` falls during it.
- R5: The receiver uses 16 oversampling ticks per bit and samples each data bit in its middle, least significant bit first. Each good byte is placed in the buffer and shown on `rx_data_o` with `rx_valid_o`. A cycle with `rx_valid_o && rx_ready_i` removes it.
- R6: A low pulse on `rxd_i` that is gone by the middle of the start bit is treated as noise, and no byte is produced.
- R7: If the stop bit is sampled as 0, the byte is discarded. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: The buffer holds 16 bytes and returns them in arrival order. `rts_o` is 1 exactly while 16 bytes are held, so it falls in the cycle after a pop from a full buffer.
- R9: A byte that completes while the buffer is full is dropped, and `overrun_o` becomes 1 and stays 1 until reset.
- R10: While `rx_valid_o` is 1 and `rx_ready_i` is 0, `rx_data_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Transmitter will take the byte this cycle |
| txd_o | output | 1 | Serial output, idle high |
| cts_i | input | 1 | Peer allows sending when 1 (asynchronous) |
| rxd_i | input | 1 | Serial input, idle high (asynchronous) |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | Receive buffer not empty |
| rx_ready_i | input | 1 | Consume the byte on rx_data_o |
| rts_o | output | 1 | 1 while receive buffer is full; peer must stop |
| overrun_o | output | 1 | Sticky: a received byte was dropped |

## Verification
If the buffer pointers or count go wrong, `rts_o` shows it at once. It stays high after a pop from a full buffer, or it rises before the sixteenth byte arrives. A wrong pointer also brings bytes out of order on the first read. A fault in the receive sampling phase shows up one frame later, either as a wrong bit in the delivered byte or as noise being accepted as a byte. A transmit counter error distorts the serial waveform within the first bit period, and the mid-bit capture in the bench reads the wrong value there. A broken CTS gate is seen within a few clocks, as `tx_ready_o` rising while `cts_i` has been low.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  localparam int unsigned OVS_RATE = 16;
  localparam int unsigned OVS_MID  = OVS_RATE / 2;

  typedef enum logic [0:0] {TX_IDLE, TX_SHIFT} tx_state_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HIGH} rx_state_e;
endpackage

// File: rtl/uart_fc_sync.sv
module uart_fc_sync #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx #(
  parameter int unsigned CLKS_PER_BIT = 32,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic              cts_s_i,
  output logic              txd_o,
  output logic              busy_o
);
  import uart_fc_pkg::*;

  localparam int unsigned CW    = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int unsigned NBITS = DATA_W + 1;  // data + stop after start
  localparam int unsigned BW    = $clog2(NBITS + 1);

  tx_state_e         state_q;
  logic [CW-1:0]     clk_cnt_q;
  logic [BW-1:0]     bit_cnt_q;
  logic [DATA_W:0]   shreg_q;
  logic              txd_q;

  assign ready_o = (state_q == TX_IDLE) && cts_s_i;
  assign busy_o  = (state_q != TX_IDLE);
  assign txd_o   = txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TX_IDLE;
      clk_cnt_q <= '0;
      bit_cnt_q <= '0;
      shreg_q   <= '1;
      txd_q     <= 1'b1;
    end else begin
      unique case (state_q)
        TX_IDLE: begin
          if (valid_i && ready_o) begin
            txd_q     <= 1'b0;
            shreg_q   <= {1'b1, data_i};
            clk_cnt_q <= '0;
            bit_cnt_q <= '0;
            state_q   <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (clk_cnt_q == CW'(CLKS_PER_BIT - 1)) begin
            clk_cnt_q <= '0;
            if (bit_cnt_q == BW'(NBITS)) begin
              state_q <= TX_IDLE;  // stop bit done, line already high
            end else begin
              txd_q     <= shreg_q[0];
              shreg_q   <= {1'b1, shreg_q[DATA_W:1]};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end
          end else begin
            clk_cnt_q <= clk_cnt_q + 1'b1;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx #(
  parameter int unsigned CLKS_PER_BIT = 32,
  parameter int unsigned DATA_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_s_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  import uart_fc_pkg::*;

  localparam int unsigned TICK_DIV = CLKS_PER_BIT / OVS_RATE;
  localparam int unsigned DIV_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned IDX_W    = $clog2(DATA_W);

  rx_state_e         state_q;
  logic [DIV_W-1:0]  div_q;
  logic [3:0]        tick_cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              valid_q;
  logic              tick;

  assign tick    = (div_q == DIV_W'(TICK_DIV - 1));
  assign data_o  = shreg_q;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= RX_IDLE;
      div_q      <= '0;
      tick_cnt_q <= '0;
      idx_q      <= '0;
      shreg_q    <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (state_q == RX_IDLE || state_q == RX_WAIT_HIGH || tick) div_q <= '0;
      else                                                      div_q <= div_q + 1'b1;

      unique case (state_q)
        RX_IDLE: begin
          tick_cnt_q <= '0;
          if (!rxd_s_i) state_q <= RX_START;
        end
        RX_START: if (tick) begin
          if (tick_cnt_q == 4'(OVS_MID - 1)) begin
            tick_cnt_q <= '0;
            idx_q      <= '0;
            state_q    <= rxd_s_i ? RX_IDLE : RX_DATA;  // reject glitch
          end else tick_cnt_q <= tick_cnt_q + 1'b1;
        end
        RX_DATA: if (tick) begin
          if (tick_cnt_q == 4'(OVS_RATE - 1)) begin
            tick_cnt_q <= '0;
            shreg_q    <= {rxd_s_i, shreg_q[DATA_W-1:1]};
            idx_q      <= idx_q + 1'b1;
            if (idx_q == IDX_W'(DATA_W - 1)) state_q <= RX_STOP;
          end else tick_cnt_q <= tick_cnt_q + 1'b1;
        end
        RX_STOP: if (tick) begin
          if (tick_cnt_q == 4'(OVS_RATE - 1)) begin
            tick_cnt_q <= '0;
            if (rxd_s_i) begin
              valid_q <= 1'b1;
              state_q <= RX_IDLE;
            end else begin
              state_q <= RX_WAIT_HIGH;
            end
          end else tick_cnt_q <= tick_cnt_q + 1'b1;
        end
        RX_WAIT_HIGH: if (rxd_s_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW:0]       wptr_q, rptr_q;
  logic              do_push, do_pop;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_push) wptr_q <= wptr_q + 1'b1;
      if (do_pop)  rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q[AW-1:0]] <= wdata_i;
  end
endmodule

// File: rtl/uart_fc.sv
module uart_fc #(
  parameter int unsigned CLKS_PER_BIT = 32,
  parameter int unsigned FIFO_DEPTH   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic       txd_o,
  input  logic       cts_i,
  input  logic       rxd_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i,
  output logic       rts_o,
  output logic       overrun_o
);
  localparam int unsigned DATA_W = 8;

  logic              cts_s, rxd_s;
  logic              tx_busy;
  logic              rx_push;
  logic [DATA_W-1:0] rx_byte;
  logic              fifo_empty, fifo_full;
  logic              overrun_q;

  uart_fc_sync #(.RESET_VAL(1'b0)) i_cts_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_i), .q_o(cts_s)
  );
  uart_fc_sync #(.RESET_VAL(1'b1)) i_rxd_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rxd_i), .q_o(rxd_s)
  );

  uart_fc_tx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .data_i(tx_data_i), .valid_i(tx_valid_i),
    .ready_o(tx_ready_o), .cts_s_i(cts_s), .txd_o(txd_o), .busy_o(tx_busy)
  );

  uart_fc_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_W(DATA_W)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rxd_s_i(rxd_s), .data_o(rx_byte), .valid_o(rx_push)
  );

  uart_fc_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .wdata_i(rx_byte), .push_i(rx_push),
    .pop_i(rx_ready_i), .rdata_o(rx_data_o), .empty_o(fifo_empty), .full_o(fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   overrun_q <= 1'b0;
    else if (rx_push && fifo_full) overrun_q <= 1'b1;
  end

  assign rx_valid_o = !fifo_empty;
  assign rts_o      = fifo_full;
  assign overrun_o  = overrun_q;
endmodule

// File: rtl/uart_fc_checker.sv
module uart_fc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cts_i,
  input logic       tx_valid_i,
  input logic       tx_ready_o,
  input logic       txd_o,
  input logic       tx_busy,
  input logic       rx_push,
  input logic       rx_ready_i,
  input logic       rx_valid_o,
  input logic [7:0] rx_data_o,
  input logic       rts_o,
  input logic       overrun_o
);
  // R3: ready only after cts seen high through the synchronizer
  assert_ready_needs_cts_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ready_o |-> $past(cts_i, 2));

  // R2: accepted byte starts with a low start bit
  assert_start_bit_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> (!txd_o && tx_busy));

  // R3: idle line stays high
  assert_idle_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> txd_o);

  // R9: byte arriving on full buffer flags overrun
  assert_overrun_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rts_o) |=> overrun_o);

  // R9: overrun is sticky
  assert_overrun_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  // R8: pop from full buffer releases rts
  assert_rts_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rts_o && rx_ready_i) |=> !rts_o);

  // R10: head byte held until consumed
  assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

bind uart_fc uart_fc_checker i_uart_fc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .cts_i(cts_i), .tx_valid_i(tx_valid_i),
  .tx_ready_o(tx_ready_o), .txd_o(txd_o), .tx_busy(tx_busy), .rx_push(rx_push),
  .rx_ready_i(rx_ready_i), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
  .rts_o(rts_o), .overrun_o(overrun_o)
);

// File: tb/test_uart_fc.sv
module test_uart_fc;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 32;
  localparam int NVEC       = 6;
  // {stimulus byte, expected byte on the far side}
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFFFF, 16'hA5A5,
                                         16'h5A5A, 16'h0101, 16'h8080};

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0, cts = 1'b0, rxd = 1'b1, rx_ready = 1'b0;
  logic tx_ready, txd, rx_valid, rts, overrun;
  logic [7:0] rx_data;
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_fc #(.CLKS_PER_BIT(CPB), .FIFO_DEPTH(16)) i_uart_fc (
    .clk_i(clk), .rst_ni(rst_n), .tx_data_i(tx_data), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .txd_o(txd), .cts_i(cts), .rxd_i(rxd),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rts_o(rts), .overrun_o(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic tx_send(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic tx_capture(output logic [7:0] b, output logic frame_ok);
    logic st;
    do @(negedge clk); while (txd !== 1'b0);
    repeat (CPB/2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (CPB) @(negedge clk);
      b[i] = txd;
    end
    repeat (CPB) @(negedge clk);
    frame_ok = (st == 1'b0) && (txd == 1'b1);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic stop_val);
    @(negedge clk);
    rxd = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (CPB) @(negedge clk);
    end
    rxd = stop_val;
    repeat (CPB) @(negedge clk);
    rxd = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  task automatic pop();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    logic ok;
    int bad;

    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 txd", txd, 1);
    chk("R1 rts", rts, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R3: cts low blocks transmission
    tx_data = 8'h3C; tx_valid = 1'b1;
    bad = 0;
    repeat (400) begin
      @(negedge clk);
      if (tx_ready || !txd) bad++;
    end
    chk("R3 blocked while cts low", bad, 0);
    tx_valid = 1'b0;
    cts = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 ready after cts high", tx_ready, 1);

    // R2: transmit vector table
    foreach (VEC[k]) begin
      fork
        tx_send(VEC[k][15:8]);
        tx_capture(got, ok);
      join
      chk("R2 tx byte", got, VEC[k][7:0]);
      chk("R2 tx framing", ok, 1);
    end

    // R4: cts drops mid-frame, frame completes
    fork
      tx_send(8'hC3);
      tx_capture(got, ok);
      begin repeat (100) @(negedge clk); cts = 1'b0; end
    join
    chk("R4 frame completes", got, 8'hC3);
    chk("R4 framing", ok, 1);
    bad = 0;
    tx_data = 8'h96; tx_valid = 1'b1;
    repeat (300) begin
      @(negedge clk);
      if (tx_ready || !txd) bad++;
    end
    chk("R3 no new frame after drop", bad, 0);
    fork
      begin cts = 1'b1; tx_send(8'h96); end
      tx_capture(got, ok);
    join
    chk("R3 pending byte sent after cts", got, 8'h96);

    // R5: receive vector table
    foreach (VEC[k]) begin
      rx_send(VEC[k][15:8], 1'b1);
      chk("R5 rx valid", rx_valid, 1);
      chk("R5 rx byte", rx_data, VEC[k][7:0]);
      pop();
      chk("R5 popped", rx_valid, 0);
    end

    // R6: short glitch rejected
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (600) @(negedge clk);
    chk("R6 glitch ignored", rx_valid, 0);

    // R7: bad stop bit discarded, then next byte ok
    rx_send(8'h77, 1'b0);
    repeat (400) @(negedge clk);
    chk("R7 framing error dropped", rx_valid, 0);
    rx_send(8'h2B, 1'b1);
    chk("R7 recovery byte", rx_data, 8'h2B);
    pop();

    // R8/R9: fill, overflow, order, rts release
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk("R8 rts low at 15", rts, 0);
      rx_send(8'h40 + 8'(i), 1'b1);
    end
    chk("R8 rts high when full", rts, 1);
    chk("R9 no overrun yet", overrun, 0);
    rx_send(8'hEE, 1'b1);
    chk("R9 overrun set", overrun, 1);
    chk("R10 head unchanged", rx_data, 8'h40);
    pop();
    chk("R8 rts released", rts, 0);
    for (int i = 1; i < 16; i++) begin
      chk("R8 order", rx_data, 8'h40 + 8'(i));
      pop();
    end
    chk("R9 dropped byte absent", rx_valid, 0);
    chk("R9 overrun sticky", overrun, 1);

    finish_run();
  end
endmodule